// File: doc/BRIEF.md
# Rotational Sector Counter and Comparator

This block keeps track of which physical sector of a rotating disc surface is passing under the heads, and flags when that sector equals a target chosen by the controller. It runs directly on the sector clock that the servo loop derives from the spindle. A prescaler divides that clock by 840. Each time the prescaler wraps, a sector counter advances. One revolution is 53,760 sector clocks, so the counter steps through 64 sectors, numbered 0 to 63. The index pulse, seen once per revolution, restarts both counters so that sector 0 always begins at the index mark.

The controller loads a target sector through an address strobe with a 6-bit address. Before the address is stored, its two upper bits are tested. An address with both of those bits set is rejected. The rejected address is not stored, and a seek-check status flag is raised instead. While a read or write command level is held, the comparator raises the sector-compare output for the part of the target sector that can carry a transfer. That window ends at prescaler count 816, so the tail of the sector stays free for the handover to the next sector.

Top module: `rsc_sector_tracker`

## Requirements
- R1: The prescaler runs through the counts 0 to 839 on successive sector clocks. The clock edge that leaves count 839 returns it to 0 and advances the sector counter, which wraps from 63 to 0. With read held and no index, sector compare is therefore high for exactly 816 clocks out of every 53,760.
- R2: When the index pulse is high at a clock edge, that edge clears both the prescaler and the sector counter, whatever their previous values.
- R3: While the active-low clear input is low, the target register holds 0 and seek check is 0. The counters are also cleared and sector compare is 0.
- R4: An address strobe carrying an address whose bit 5 and bit 4 are not both 1 stores that address as the target at the clock edge, and clears seek check.
- R5: An address strobe carrying an address with bit 5 and bit 4 both 1 (values 48 to 63) leaves the target unchanged and sets seek check at the clock edge.
- R6: Sector compare goes high at the clock edge where read or write is high, the sector counter equals the target, and the prescaler is below 816.
- R7: Sector compare goes low at the clock edge where the prescaler is at 816, and it stays low for the rest of that sector.
- R8: Sector compare is low one clock after both the read and write command levels are low.
- R9: Seek check keeps its value until the clear input goes low or a legal address strobe arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sector clock, phase-locked to the servo code |
| clr_n | input | 1 | Power-up / run clear, active low, asynchronous |
| index_pulse | input | 1 | Once-per-revolution index, sampled on clk |
| adr_strobe | input | 1 | Address command strobe, one clock per command |
| adr_data | input | 6 | Target sector address carried with the strobe |
| rd_cmd | input | 1 | Read command level |
| wr_cmd | input | 1 | Write command level |
| sect_match | output | 1 | Sector compare: target sector is under the heads and a read or write is active |
| seek_check | output | 1 | Set by an illegal address command |

## Verification
On every clock, the bound assertions check the following:
- the prescaler stays in range and the sector counter steps at each prescaler wrap;
- the index pulse clears both counters;
- legal strobes load the target and illegal strobes leave it alone;
- seek check holds between strobes;
- sector compare is gated by the read/write levels and by the count-816 cutoff.

Some behaviours span thousands of clocks, and only the bench scenarios can show them. These include the exact 816-clock compare window per revolution, the wrap back to sector 0 without an index, and the fact that a rejected address leaves an earlier target still in use. The bench also shows the re-alignment to sector 0 when an index arrives mid-sector, and a clear issued in the middle of a transfer.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
   // Result of decoding one address command
   typedef enum logic [1:0] {
      ADR_IDLE    = 2'd0,
      ADR_ACCEPT  = 2'd1,
      ADR_REJECT  = 2'd2
   } adr_kind_e;

   // Default geometry of one revolution
   localparam int unsigned DEF_PRESCALE = 840;
   localparam int unsigned DEF_SECTORS  = 64;
   localparam int unsigned DEF_END_CNT  = 816;
   localparam int unsigned DEF_BAD_MASK = 'h30;
endpackage

// File: rtl/rsc_rev_counter.sv
module rsc_rev_counter #(
   parameter int unsigned PRESCALE = 840,
   parameter int unsigned SECTORS  = 64,
   parameter int unsigned PRE_W    = 10,
   parameter int unsigned SEC_W    = 6
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             index_pulse,
   output logic [PRE_W-1:0] pre_cnt,
   output logic [SEC_W-1:0] sec_cnt
);
   localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
   localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SECTORS - 1);

   logic             pre_wrap;
   logic [SEC_W-1:0] sec_inc;

   assign pre_wrap = (pre_cnt == PRE_LAST);

   generate
      if (SECTORS == (1 << SEC_W)) begin : g_pow2_wrap
         assign sec_inc = sec_cnt + 1'b1;
      end else begin : g_cmp_wrap
         assign sec_inc = (sec_cnt == SEC_LAST) ? '0 : sec_cnt + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         pre_cnt <= '0;
         sec_cnt <= '0;
      end else if (index_pulse) begin
         pre_cnt <= '0;
         sec_cnt <= '0;
      end else if (pre_wrap) begin
         pre_cnt <= '0;
         sec_cnt <= sec_inc;
      end else begin
         pre_cnt <= pre_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/rsc_target_reg.sv
module rsc_target_reg
   import rsc_pkg::*;
#(
   parameter int unsigned ADR_W    = 6,
   parameter int unsigned BAD_MASK = 'h30
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             adr_strobe,
   input  logic [ADR_W-1:0] adr_data,
   output logic [ADR_W-1:0] target,
   output logic             seek_check
);
   localparam logic [ADR_W-1:0] MASK = ADR_W'(BAD_MASK);

   adr_kind_e kind;

   always_comb begin
      if (!adr_strobe)
         kind = ADR_IDLE;
      else if ((adr_data & MASK) == MASK)
         kind = ADR_REJECT;
      else
         kind = ADR_ACCEPT;
   end

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         target     <= '0;
         seek_check <= 1'b0;
      end else begin
         unique case (kind)
            ADR_ACCEPT: begin
               target     <= adr_data;
               seek_check <= 1'b0;
            end
            ADR_REJECT: seek_check <= 1'b1;
            default:    ;
         endcase
      end
   end
endmodule

// File: rtl/rsc_compare.sv
module rsc_compare #(
   parameter int unsigned PRE_W   = 10,
   parameter int unsigned SEC_W   = 6,
   parameter int unsigned END_CNT = 816
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             rw_active,
   input  logic [PRE_W-1:0] pre_cnt,
   input  logic [SEC_W-1:0] sec_cnt,
   input  logic [SEC_W-1:0] target,
   output logic             sect_match
);
   localparam logic [PRE_W-1:0] END_V = PRE_W'(END_CNT);

   logic same_sector;
   logic in_window;

   assign same_sector = (sec_cnt == target);
   assign in_window   = (pre_cnt < END_V);

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)
         sect_match <= 1'b0;
      else
         sect_match <= rw_active && same_sector && in_window;
   end
endmodule

// File: rtl/rsc_sector_tracker.sv
module rsc_sector_tracker #(
   parameter int unsigned PRESCALE = rsc_pkg::DEF_PRESCALE,
   parameter int unsigned SECTORS  = rsc_pkg::DEF_SECTORS,
   parameter int unsigned END_CNT  = rsc_pkg::DEF_END_CNT,
   parameter int unsigned BAD_MASK = rsc_pkg::DEF_BAD_MASK,
   localparam int unsigned PRE_W   = $clog2(PRESCALE),
   localparam int unsigned SEC_W   = $clog2(SECTORS)
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             index_pulse,
   input  logic             adr_strobe,
   input  logic [SEC_W-1:0] adr_data,
   input  logic             rd_cmd,
   input  logic             wr_cmd,
   output logic             sect_match,
   output logic             seek_check
);
   generate
      if (PRESCALE < 2) begin : g_bad_prescale
         $error("PRESCALE must be at least 2");
      end
      if (SECTORS < 2) begin : g_bad_sectors
         $error("SECTORS must be at least 2");
      end
      if (END_CNT == 0 || END_CNT >= PRESCALE) begin : g_bad_end
         $error("END_CNT must lie inside the prescaler range");
      end
      if (BAD_MASK == 0 || BAD_MASK >= (1 << SEC_W)) begin : g_bad_mask
         $error("BAD_MASK must be a non-zero address bit set");
      end
   endgenerate

   logic [PRE_W-1:0] pre_cnt;
   logic [SEC_W-1:0] sec_cnt;
   logic [SEC_W-1:0] target;

   rsc_rev_counter #(
      .PRESCALE (PRESCALE),
      .SECTORS  (SECTORS),
      .PRE_W    (PRE_W),
      .SEC_W    (SEC_W)
   ) u_rev (
      .clk         (clk),
      .clr_n       (clr_n),
      .index_pulse (index_pulse),
      .pre_cnt     (pre_cnt),
      .sec_cnt     (sec_cnt)
   );

   rsc_target_reg #(
      .ADR_W    (SEC_W),
      .BAD_MASK (BAD_MASK)
   ) u_tgt (
      .clk        (clk),
      .clr_n      (clr_n),
      .adr_strobe (adr_strobe),
      .adr_data   (adr_data),
      .target     (target),
      .seek_check (seek_check)
   );

   rsc_compare #(
      .PRE_W   (PRE_W),
      .SEC_W   (SEC_W),
      .END_CNT (END_CNT)
   ) u_cmp (
      .clk        (clk),
      .clr_n      (clr_n),
      .rw_active  (rd_cmd | wr_cmd),
      .pre_cnt    (pre_cnt),
      .sec_cnt    (sec_cnt),
      .target     (target),
      .sect_match (sect_match)
   );
endmodule

// File: rtl/rsc_checks.sv
module rsc_checks #(
   parameter int unsigned PRESCALE = 840,
   parameter int unsigned SECTORS  = 64,
   parameter int unsigned END_CNT  = 816,
   parameter int unsigned BAD_MASK = 'h30,
   parameter int unsigned PRE_W    = 10,
   parameter int unsigned SEC_W    = 6
) (
   input logic             clk,
   input logic             clr_n,
   input logic             index_pulse,
   input logic             adr_strobe,
   input logic [SEC_W-1:0] adr_data,
   input logic             rd_cmd,
   input logic             wr_cmd,
   input logic [PRE_W-1:0] pre_cnt,
   input logic [SEC_W-1:0] sec_cnt,
   input logic [SEC_W-1:0] target,
   input logic             sect_match,
   input logic             seek_check
);
   logic bad_adr;
   assign bad_adr = ((adr_data & SEC_W'(BAD_MASK)) == SEC_W'(BAD_MASK));

   AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!clr_n)
      int'(pre_cnt) < PRESCALE); // R1
   AST_SECTOR_STEP: assert property (@(posedge clk) disable iff (!clr_n)
      (!index_pulse && int'(pre_cnt) == PRESCALE - 1) |=>
      (pre_cnt == '0 && int'(sec_cnt) == (int'($past(sec_cnt)) + 1) % SECTORS)); // R1
   AST_INDEX_CLEAR: assert property (@(posedge clk) disable iff (!clr_n)
      index_pulse |=> (pre_cnt == '0 && sec_cnt == '0)); // R2
   AST_LEGAL_LOAD: assert property (@(posedge clk) disable iff (!clr_n)
      (adr_strobe && !bad_adr) |=> (target == $past(adr_data) && !seek_check)); // R4
   AST_ILLEGAL_KEEP: assert property (@(posedge clk) disable iff (!clr_n)
      (adr_strobe && bad_adr) |=> ($stable(target) && seek_check)); // R5
   AST_MATCH_SET: assert property (@(posedge clk) disable iff (!clr_n)
      ((rd_cmd || wr_cmd) && sec_cnt == target && int'(pre_cnt) < END_CNT) |=> sect_match); // R6
   AST_END_DROP: assert property (@(posedge clk) disable iff (!clr_n)
      (int'(pre_cnt) >= END_CNT) |=> !sect_match); // R7
   AST_RW_GATE: assert property (@(posedge clk) disable iff (!clr_n)
      (!rd_cmd && !wr_cmd) |=> !sect_match); // R8
   AST_CHECK_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
      !adr_strobe |=> $stable(seek_check)); // R9
endmodule

bind rsc_sector_tracker rsc_checks #(
   .PRESCALE (PRESCALE),
   .SECTORS  (SECTORS),
   .END_CNT  (END_CNT),
   .BAD_MASK (BAD_MASK),
   .PRE_W    (PRE_W),
   .SEC_W    (SEC_W)
) u_checks (
   .clk         (clk),
   .clr_n       (clr_n),
   .index_pulse (index_pulse),
   .adr_strobe  (adr_strobe),
   .adr_data    (adr_data),
   .rd_cmd      (rd_cmd),
   .wr_cmd      (wr_cmd),
   .pre_cnt     (pre_cnt),
   .sec_cnt     (sec_cnt),
   .target      (target),
   .sect_match  (sect_match),
   .seek_check  (seek_check)
);

// File: tb/sim_rsc_sector_tracker.sv
module sim_rsc_sector_tracker;
   localparam int CLK_PERIOD = 10;
   localparam int REV        = 53760;
   localparam int SECT_LEN   = 840;

   logic       clk = 1'b0;
   logic       clr_n = 1'b0;
   logic       index_pulse = 1'b0;
   logic       adr_strobe = 1'b0;
   logic [5:0] adr_data = '0;
   logic       rd_cmd = 1'b0;
   logic       wr_cmd = 1'b0;
   logic       sect_match;
   logic       seek_check;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rsc_sector_tracker u0 (
      .clk(clk), .clr_n(clr_n), .index_pulse(index_pulse),
      .adr_strobe(adr_strobe), .adr_data(adr_data),
      .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
      .sect_match(sect_match), .seek_check(seek_check));

   // behavioural reference: position in revolution, target, flags
   int  m_pos = 0;
   int  m_tgt = 0;
   bit  m_chk = 0;
   bit  m_sc  = 0;

   always @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         m_pos = 0; m_tgt = 0; m_chk = 0; m_sc = 0;
      end else begin
         int sec_now, off_now;
         sec_now = m_pos / SECT_LEN;
         off_now = m_pos % SECT_LEN;
         m_sc = (rd_cmd || wr_cmd) && (sec_now == m_tgt) && (off_now < 816);
         if (index_pulse) m_pos = 0;
         else             m_pos = (m_pos + 1) % REV;
         if (adr_strobe) begin
            if (adr_data[5] && adr_data[4]) m_chk = 1;
            else begin m_tgt = adr_data; m_chk = 0; end
         end
      end
   end

   // every-cycle comparison against the reference
   always @(negedge clk) begin
      if (!done) begin
         n_cmp++;
         if (sect_match !== m_sc || seek_check !== m_chk) begin
            n_bad++;
            $display("FAIL R6/R7/R8/R9 cycle compare: sect_match=%0b seek_check=%0b expected %0b %0b",
                     sect_match, seek_check, m_sc, m_chk);
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic count_hi(input int n, output int hi);
      hi = 0;
      repeat (n) begin
         @(negedge clk);
         if (sect_match) hi++;
      end
      #1;
   endtask

   task automatic strobe(input logic [5:0] a);
      adr_strobe = 1'b1; adr_data = a;
      idle(1);
      adr_strobe = 1'b0; adr_data = '0;
   endtask

   task automatic pulse_index();
      index_pulse = 1'b1;
      idle(1);
      index_pulse = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not end, actual=timeout expected=done");
      finish_run();
   end

   initial begin
      int hi;
      idle(3);
      check("R3 reset sect_match", int'(sect_match), 0);
      check("R3 reset seek_check", int'(seek_check), 0);
      clr_n = 1'b1;
      idle(2);

      // R4 legal load of sector 2, R6/R7 one window of 816 clocks
      pulse_index();
      strobe(6'd2);
      check("R4 legal strobe clears seek_check", int'(seek_check), 0);
      rd_cmd = 1'b1;
      count_hi(3000, hi);
      check("R6 R7 compare window length in sector 2", hi, 816);

      // R2 index mid-revolution re-aligns to sector 0
      strobe(6'd0);
      idle(5);
      check("R2 no compare before index", int'(sect_match), 0);
      pulse_index();
      idle(1);
      check("R2 compare right after index", int'(sect_match), 1);

      // R8 dropping read removes compare, write restores it
      rd_cmd = 1'b0;
      idle(1);
      check("R8 compare drops with read", int'(sect_match), 0);
      wr_cmd = 1'b1;
      idle(1);
      check("R6 compare on write", int'(sect_match), 1);
      wr_cmd = 1'b0;
      idle(1);

      // R5 illegal addresses, R9 hold
      strobe(6'd53);
      check("R5 illegal 53 sets seek_check", int'(seek_check), 1);
      idle(200);
      check("R9 seek_check held", int'(seek_check), 1);
      strobe(6'd48);
      check("R5 illegal 48 keeps seek_check", int'(seek_check), 1);
      rd_cmd = 1'b1;
      pulse_index();
      count_hi(500, hi);
      check("R5 target 0 kept after illegal strobes", (hi > 0) ? 1 : 0, 1);
      rd_cmd = 1'b0;
      strobe(6'd47);
      check("R9 legal 47 clears seek_check", int'(seek_check), 0);

      // R4 far legal sector 47 (bit5=1, bit4=0)
      rd_cmd = 1'b1;
      pulse_index();
      count_hi(47 * SECT_LEN + 900, hi);
      check("R4 compare window in sector 47", hi, 816);

      // R1 full revolution without index: one window per 53760 clocks
      strobe(6'd5);
      idle(10);
      count_hi(REV, hi);
      check("R1 one compare window per revolution", hi, 816);

      // R3 clear in the middle of a transfer
      strobe(6'd63);
      check("R5 illegal 63 sets seek_check", int'(seek_check), 1);
      clr_n = 1'b0;
      idle(1);
      check("R3 clear drops sect_match", int'(sect_match), 0);
      check("R3 clear drops seek_check", int'(seek_check), 0);
      clr_n = 1'b1;
      idle(1);
      check("R3 target 0 after clear, sector 0 compare", int'(sect_match), 1);
      rd_cmd = 1'b0;
      idle(4);
      finish_run();
   end
endmodule